// File: doc/BRIEF.md
# Two-Stage Cascaded Priority Interrupt Controller

This block merges sixteen level-sensitive interrupt request lines into one interrupt output for a processor. It is built from two identical eight-input priority units, a first stage and a second stage. The second stage's combined request takes the place of first-stage input 2, so global levels 8 to 15 reach the processor through that one input. Each unit keeps a mask register, an in-service register and a rotating priority pointer. Software reaches both units over a small register bus. A select line picks the stage, one address bit picks the command/status port or the mask port, and there are separate read and write strobes and an 8-bit data bus.

The processor answers `irq_o` by pulsing `iack_i`. An acknowledge state machine then resolves the winning level, marks it in service and returns the global level number on `vector_o` while `vec_valid_o` pulses. The machine has three states. ACK_IDLE waits for `iack_i`. ACK_SLAVE resolves the second stage and is entered only when the first-stage winner is the cascade input. ACK_DONE presents the vector for one cycle. The transitions are: ACK_IDLE to ACK_SLAVE on `iack_i` when the cascade input wins, ACK_IDLE to ACK_DONE on `iack_i` in every other case, ACK_SLAVE to ACK_DONE always, and ACK_DONE to ACK_IDLE always.

Software ends a service routine by writing a specific end-of-interrupt command. That command clears the in-service bit and also rotates priority, so the finished level becomes the lowest priority in its unit.

Top module: `cascade_irq_ctrl`

## Requirements
- R1: After reset, both mask registers read back 0xFF and `irq_o` stays low even with every request line high.
- R2: Writing port 1 (`addr_i`=1) of a unit loads its mask register, and that port reads back the written value. A mask bit of 1 keeps its input from raising `irq_o`, and a bit of 0 lets it.
- R3: Reading port 0 (`addr_i`=0) returns that unit's raw request lines one cycle after the `rd_i` strobe. For the first stage, bit 2 shows the second stage's combined request.
- R4: After reset, input 0 of each unit has the highest priority and input 7 the lowest. An acknowledge returns the highest-priority enabled pending level as its global number. `vec_valid_o` rises in the cycle after the `iack_i` edge for levels 0 to 7.
- R5: An acknowledged level is marked in service. While it is in service, requests of equal or lower priority keep `irq_o` low, and a request of higher priority raises it.
- R6: A write to port 0 of a byte with bits 7:5 = 111 and bits 4:3 = 00 clears the in-service bit of level bits 2:0 and makes that level the lowest priority of the unit. Any other command byte is ignored.
- R7: A second-stage request wins through first-stage input 2 and returns vector 8 plus the local index, with `vec_valid_o` two cycles after the `iack_i` edge. First-stage level 2 stays in service until it gets its own end-of-interrupt. The external line `req_i[2]` is ignored.
- R8: An acknowledge with no winner returns 7 (first stage) or 15 (second stage, if the cascade request has vanished) and marks no level in service.
- R9: `vec_valid_o` is a single-cycle pulse for each acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 16 | Level-sensitive request lines, bit n is global level n (bit 2 unused) |
| cs_slave_i | input | 1 | Register select: 0 first stage, 1 second stage |
| addr_i | input | 1 | 0 command/status port, 1 mask port |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe; `rdata_o` updates on the next edge |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| iack_i | input | 1 | Interrupt acknowledge strobe, one cycle |
| vector_o | output | 8 | Acknowledged global level number |
| vec_valid_o | output | 1 | One-cycle pulse when `vector_o` is valid |
| irq_o | output | 1 | Interrupt request to the processor |

## Verification
A corrupted in-service bit or priority pointer is invisible on `rdata_o`. It shows up as a wrong level on `irq_o` within one cycle of the next request change, or as a wrong vector on the next acknowledge. For that reason the tests chain acknowledges and end-of-interrupts so that each rotation is judged by the following winner. A wrong cascade decision shows up as a vector outside the expected stage, or as `vec_valid_o` arriving one cycle early or late.

// File: rtl/irq_pkg.sv
package irq_pkg;

    // Acknowledge sequencer states
    typedef enum logic [1:0] {
        ACK_IDLE  = 2'd0,
        ACK_SLAVE = 2'd1,
        ACK_DONE  = 2'd2
    } ack_state_e;

    // Command byte: top three bits select specific end-of-interrupt with rotation
    localparam int          CMD_OPC_LSB = 5;
    localparam logic [2:0]  CMD_OPC_EOI = 3'b111;

endpackage

// File: rtl/irq_prio_resolver.sv
module irq_prio_resolver #(
    parameter int N = 8
) (
    input  logic [N-1:0]         req_i,
    input  logic [N-1:0]         mask_i,
    input  logic [N-1:0]         isr_i,
    input  logic [$clog2(N)-1:0] lowest_i,
    output logic                 int_o,
    output logic [$clog2(N)-1:0] win_idx_o
);
    localparam int IDX_W = $clog2(N);

    logic             win_found;
    logic [IDX_W-1:0] win_rank;
    logic             isr_found;
    logic [IDX_W-1:0] isr_rank;

    // Scan from the position just above the lowest one, wrapping around.
    always_comb begin : scan
        logic [IDX_W-1:0] pos;
        win_found = 1'b0;
        win_rank  = '0;
        win_idx_o = '0;
        isr_found = 1'b0;
        isr_rank  = '0;
        pos       = '0;
        for (int r = 0; r < N; r++) begin
            pos = lowest_i + IDX_W'(r + 1);
            if (!win_found && req_i[pos] && !mask_i[pos]) begin
                win_found = 1'b1;
                win_rank  = IDX_W'(r);
                win_idx_o = pos;
            end
            if (!isr_found && isr_i[pos]) begin
                isr_found = 1'b1;
                isr_rank  = IDX_W'(r);
            end
        end
    end

    assign int_o = win_found && (!isr_found || (win_rank < isr_rank));

endmodule

// File: rtl/irq_unit.sv
module irq_unit
    import irq_pkg::*;
#(
    parameter int N      = 8,
    parameter int DATA_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [N-1:0]         req_i,
    input  logic                 mask_wr_i,
    input  logic                 cmd_wr_i,
    input  logic [DATA_W-1:0]    wdata_i,
    input  logic                 set_isr_i,
    input  logic [$clog2(N)-1:0] set_idx_i,
    output logic [N-1:0]         mask_o,
    output logic [N-1:0]         status_o,
    output logic                 int_o,
    output logic [$clog2(N)-1:0] win_idx_o
);
    localparam int IDX_W = $clog2(N);

    logic [N-1:0]     mask_q;
    logic [N-1:0]     isr_q;
    logic [N-1:0]     isr_d;
    logic [IDX_W-1:0] lowest_q;
    logic             eoi_fire;
    logic [IDX_W-1:0] eoi_idx;

    assign eoi_fire = cmd_wr_i
                   && (wdata_i[DATA_W-1:CMD_OPC_LSB] == CMD_OPC_EOI)
                   && (wdata_i[CMD_OPC_LSB-1:IDX_W] == '0);
    assign eoi_idx  = wdata_i[IDX_W-1:0];

    always_comb begin
        isr_d = isr_q;
        if (set_isr_i) isr_d = isr_d | (N'(1) << set_idx_i);
        if (eoi_fire)  isr_d = isr_d & ~(N'(1) << eoi_idx);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q   <= '1;
            isr_q    <= '0;
            lowest_q <= IDX_W'(N - 1);
        end else begin
            if (mask_wr_i) mask_q <= wdata_i[N-1:0];
            isr_q <= isr_d;
            if (eoi_fire) lowest_q <= eoi_idx;
        end
    end

    irq_prio_resolver #(.N(N)) u_resolver (
        .req_i     (req_i),
        .mask_i    (mask_q),
        .isr_i     (isr_q),
        .lowest_i  (lowest_q),
        .int_o     (int_o),
        .win_idx_o (win_idx_o)
    );

    assign mask_o   = mask_q;
    assign status_o = req_i;

    // R1: reset leaves every input disabled
    assert_reset_masks_R1: assert property (@(posedge clk)
        !rst_n |=> (mask_q == '1));

    // R2: a presented winner is a pending, unmasked input
    assert_winner_enabled_R2: assert property (@(posedge clk) disable iff (!rst_n)
        int_o |-> (req_i[win_idx_o] && !mask_q[win_idx_o]));

    // R5: in-service bits appear only through an acknowledge
    assert_isr_only_on_ack_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ((isr_q & ~$past(isr_q)) != '0) |-> $past(set_isr_i));

    // R6: end-of-interrupt clears the named level
    assert_eoi_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        eoi_fire |=> !isr_q[$past(eoi_idx)]);

endmodule

// File: rtl/irq_ack_fsm.sv
module irq_ack_fsm
    import irq_pkg::*;
#(
    parameter int IDX_W      = 3,
    parameter int VEC_W      = 8,
    parameter int CASCADE_IN = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             iack_i,
    input  logic             m_int_i,
    input  logic [IDX_W-1:0] m_win_i,
    input  logic             s_int_i,
    input  logic [IDX_W-1:0] s_win_i,
    output logic             m_set_o,
    output logic [IDX_W-1:0] m_set_idx_o,
    output logic             s_set_o,
    output logic [IDX_W-1:0] s_set_idx_o,
    output logic             vec_valid_o,
    output logic [VEC_W-1:0] vector_o,
    output logic             idle_o
);
    localparam logic [IDX_W-1:0] CASC_IDX   = IDX_W'(CASCADE_IN);
    localparam logic [VEC_W-1:0] SPUR_FIRST = VEC_W'({1'b0, {IDX_W{1'b1}}});
    localparam logic [VEC_W-1:0] SPUR_SECND = VEC_W'({1'b1, {IDX_W{1'b1}}});

    ack_state_e       state_q, state_d;
    logic [VEC_W-1:0] vec_q;
    logic             take_cascade;

    assign take_cascade = m_int_i && (m_win_i == CASC_IDX);

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ACK_IDLE:  if (iack_i) state_d = take_cascade ? ACK_SLAVE : ACK_DONE;
            ACK_SLAVE: state_d = ACK_DONE;
            ACK_DONE:  state_d = ACK_IDLE;
            default:   state_d = ACK_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ACK_IDLE;
        else        state_q <= state_d;
    end

    // Outputs
    always_comb begin
        m_set_o     = 1'b0;
        s_set_o     = 1'b0;
        vec_valid_o = 1'b0;
        idle_o      = 1'b0;
        m_set_idx_o = m_win_i;
        s_set_idx_o = s_win_i;
        unique case (state_q)
            ACK_IDLE: begin
                idle_o  = 1'b1;
                m_set_o = iack_i && m_int_i;
            end
            ACK_SLAVE: s_set_o     = s_int_i;
            ACK_DONE:  vec_valid_o = 1'b1;
            default:   idle_o      = 1'b0;
        endcase
    end

    // Vector capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= '0;
        end else if (state_q == ACK_IDLE && iack_i) begin
            vec_q <= m_int_i ? VEC_W'(m_win_i) : SPUR_FIRST;
        end else if (state_q == ACK_SLAVE) begin
            vec_q <= s_int_i ? VEC_W'({1'b1, s_win_i}) : SPUR_SECND;
        end
    end

    assign vector_o = vec_q;

    // R9: one vector strobe per acknowledge
    assert_vec_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid_o |=> !vec_valid_o);

    // R7: second stage is consulted only after the cascade input was taken
    assert_cascade_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ACK_SLAVE) |-> ($past(m_set_o) && ($past(m_set_idx_o) == CASC_IDX)));

endmodule

// File: rtl/cascade_irq_ctrl.sv
module cascade_irq_ctrl #(
    parameter int UNIT_N     = 8,
    parameter int DATA_W     = 8,
    parameter int CASCADE_IN = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*UNIT_N-1:0]   req_i,
    input  logic                  cs_slave_i,
    input  logic                  addr_i,
    input  logic                  wr_i,
    input  logic                  rd_i,
    input  logic [DATA_W-1:0]     wdata_i,
    output logic [DATA_W-1:0]     rdata_o,
    input  logic                  iack_i,
    output logic [DATA_W-1:0]     vector_o,
    output logic                  vec_valid_o,
    output logic                  irq_o
);
    localparam int IDX_W = $clog2(UNIT_N);

    logic [UNIT_N-1:0] m_req, s_req;
    logic [UNIT_N-1:0] m_mask, s_mask, m_status, s_status;
    logic              m_int, s_int;
    logic [IDX_W-1:0]  m_win, s_win;
    logic              m_set, s_set;
    logic [IDX_W-1:0]  m_set_idx, s_set_idx;
    logic              ack_idle;
    logic              unused_cascade_line;
    logic [DATA_W-1:0] rdata_q;

    // Request routing: the cascade input of the first stage carries the second stage
    for (genvar g = 0; g < UNIT_N; g++) begin : g_route
        if (g == CASCADE_IN) begin : g_casc
            assign m_req[g] = s_int;
        end else begin : g_line
            assign m_req[g] = req_i[g];
        end
    end
    assign s_req               = req_i[2*UNIT_N-1:UNIT_N];
    assign unused_cascade_line = req_i[CASCADE_IN];

    irq_unit #(.N(UNIT_N), .DATA_W(DATA_W)) u_first (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (m_req),
        .mask_wr_i (wr_i && !cs_slave_i && addr_i),
        .cmd_wr_i  (wr_i && !cs_slave_i && !addr_i),
        .wdata_i   (wdata_i),
        .set_isr_i (m_set),
        .set_idx_i (m_set_idx),
        .mask_o    (m_mask),
        .status_o  (m_status),
        .int_o     (m_int),
        .win_idx_o (m_win)
    );

    irq_unit #(.N(UNIT_N), .DATA_W(DATA_W)) u_second (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (s_req),
        .mask_wr_i (wr_i && cs_slave_i && addr_i),
        .cmd_wr_i  (wr_i && cs_slave_i && !addr_i),
        .wdata_i   (wdata_i),
        .set_isr_i (s_set),
        .set_idx_i (s_set_idx),
        .mask_o    (s_mask),
        .status_o  (s_status),
        .int_o     (s_int),
        .win_idx_o (s_win)
    );

    irq_ack_fsm #(.IDX_W(IDX_W), .VEC_W(DATA_W), .CASCADE_IN(CASCADE_IN)) u_ack (
        .clk         (clk),
        .rst_n       (rst_n),
        .iack_i      (iack_i),
        .m_int_i     (m_int),
        .m_win_i     (m_win),
        .s_int_i     (s_int),
        .s_win_i     (s_win),
        .m_set_o     (m_set),
        .m_set_idx_o (m_set_idx),
        .s_set_o     (s_set),
        .s_set_idx_o (s_set_idx),
        .vec_valid_o (vec_valid_o),
        .vector_o    (vector_o),
        .idle_o      (ack_idle)
    );

    // Register read path
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= '0;
        end else if (rd_i) begin
            unique case ({cs_slave_i, addr_i})
                2'b00:   rdata_q <= DATA_W'(m_status);
                2'b01:   rdata_q <= DATA_W'(m_mask);
                2'b10:   rdata_q <= DATA_W'(s_status);
                default: rdata_q <= DATA_W'(s_mask);
            endcase
        end
    end

    assign rdata_o = rdata_q;
    assign irq_o   = m_int && ack_idle;

endmodule

// File: tb/test_cascade_irq_ctrl.sv
module test_cascade_irq_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] req_i = '0;
    logic        cs_slave_i = 1'b0;
    logic        addr_i = 1'b0;
    logic        wr_i = 1'b0;
    logic        rd_i = 1'b0;
    logic [7:0]  wdata_i = '0;
    logic [7:0]  rdata_o;
    logic        iack_i = 1'b0;
    logic [7:0]  vector_o;
    logic        vec_valid_o;
    logic        irq_o;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    cascade_irq_ctrl i_cascade_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .cs_slave_i(cs_slave_i),
        .addr_i(addr_i), .wr_i(wr_i), .rd_i(rd_i), .wdata_i(wdata_i),
        .rdata_o(rdata_o), .iack_i(iack_i), .vector_o(vector_o),
        .vec_valid_o(vec_valid_o), .irq_o(irq_o)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        req_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic bus_write(input logic sel, input logic adr, input logic [7:0] d);
        @(negedge clk);
        cs_slave_i = sel; addr_i = adr; wdata_i = d; wr_i = 1'b1;
        @(negedge clk);
        wr_i = 1'b0;
    endtask

    task automatic bus_read(input logic sel, input logic adr, output logic [7:0] d);
        @(negedge clk);
        cs_slave_i = sel; addr_i = adr; rd_i = 1'b1;
        @(negedge clk);
        rd_i = 1'b0;
        d = rdata_o;
    endtask

    task automatic settle();
        @(negedge clk);
    endtask

    // Pulses iack, returns vector and the number of cycles to vec_valid
    task automatic do_ack(input logic drop_slave, output logic [7:0] vec, output int lat);
        @(negedge clk);
        iack_i = 1'b1;
        @(negedge clk);
        iack_i = 1'b0;
        if (drop_slave) req_i[15:8] = '0;
        lat = 1;
        while (!vec_valid_o && lat < 5) begin
            @(negedge clk);
            lat++;
        end
        vec = vector_o;
        @(negedge clk);
        chk("R9 vec_valid single pulse", 16'(vec_valid_o), 16'd0);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        do_reset();
        req_i = 16'hFFFF;
        settle();
        chk("R1 irq low after reset", 16'(irq_o), 16'd0);
        bus_read(1'b0, 1'b1, d);
        chk("R1 first mask", 16'(d), 16'h00FF);
        bus_read(1'b1, 1'b1, d);
        chk("R1 second mask", 16'(d), 16'h00FF);
    endtask

    task automatic t_mask();
        logic [7:0] d;
        do_reset();
        bus_write(1'b0, 1'b1, 8'hAA);
        bus_write(1'b1, 1'b1, 8'h55);
        bus_read(1'b0, 1'b1, d);
        chk("R2 first mask readback", 16'(d), 16'h00AA);
        bus_read(1'b1, 1'b1, d);
        chk("R2 second mask readback", 16'(d), 16'h0055);
        req_i = 16'h0002;
        settle();
        chk("R2 masked input silent", 16'(irq_o), 16'd0);
        bus_write(1'b0, 1'b1, 8'hFD);
        settle();
        chk("R2 unmasked input raises irq", 16'(irq_o), 16'd1);
    endtask

    task automatic t_priority();
        logic [7:0] d;
        logic [7:0] v;
        int lat;
        do_reset();
        bus_write(1'b0, 1'b1, 8'h00);
        req_i = 16'h0013;
        bus_read(1'b0, 1'b0, d);
        chk("R3 first status", 16'(d), 16'h0013);
        req_i = 16'h0028;
        settle();
        chk("R4 irq raised", 16'(irq_o), 16'd1);
        do_ack(1'b0, v, lat);
        chk("R4 vector fixed priority", 16'(v), 16'd3);
        chk("R4 latency", 16'(lat), 16'd1);
        chk("R5 lower level blocked", 16'(irq_o), 16'd0);
        req_i = 16'h002A;
        settle();
        chk("R5 higher level preempts", 16'(irq_o), 16'd1);
        do_ack(1'b0, v, lat);
        chk("R5 nested vector", 16'(v), 16'd1);
        bus_write(1'b0, 1'b0, 8'hE1);
        settle();
        chk("R6 rotation keeps level 3 in service", 16'(irq_o), 16'd0);
        bus_write(1'b0, 1'b0, 8'hE3);
        settle();
        chk("R6 irq after second eoi", 16'(irq_o), 16'd1);
        do_ack(1'b0, v, lat);
        chk("R6 rotated winner", 16'(v), 16'd5);
        bus_write(1'b0, 1'b0, 8'h20);
        bus_write(1'b0, 1'b0, 8'hED);
        settle();
        chk("R6 other commands ignored", 16'(irq_o), 16'd0);
        bus_write(1'b0, 1'b0, 8'hE5);
        settle();
        do_ack(1'b0, v, lat);
        chk("R6 winner after rotation to 5", 16'(v), 16'd1);
    endtask

    task automatic t_cascade();
        logic [7:0] d;
        logic [7:0] v;
        int lat;
        do_reset();
        bus_write(1'b0, 1'b1, 8'h00);
        bus_write(1'b1, 1'b1, 8'h00);
        req_i = 16'h0004;
        settle();
        chk("R7 line 2 ignored", 16'(irq_o), 16'd0);
        req_i = 16'h1040;
        bus_read(1'b0, 1'b0, d);
        chk("R3 first status shows cascade", 16'(d), 16'h0044);
        bus_read(1'b1, 1'b0, d);
        chk("R3 second status", 16'(d), 16'h0010);
        do_ack(1'b0, v, lat);
        chk("R7 cascaded vector", 16'(v), 16'd12);
        chk("R7 cascaded latency", 16'(lat), 16'd2);
        chk("R5 cascade blocks lower level", 16'(irq_o), 16'd0);
        bus_write(1'b1, 1'b0, 8'hE4);
        settle();
        chk("R7 first stage still in service", 16'(irq_o), 16'd0);
        req_i = 16'h0040;
        bus_write(1'b0, 1'b0, 8'hE2);
        settle();
        chk("R7 irq after both eoi", 16'(irq_o), 16'd1);
        do_ack(1'b0, v, lat);
        chk("R4 vector after cascade", 16'(v), 16'd6);
        chk("R4 latency after cascade", 16'(lat), 16'd1);
    endtask

    task automatic t_spurious();
        logic [7:0] v;
        int lat;
        do_reset();
        bus_write(1'b0, 1'b1, 8'h00);
        do_ack(1'b0, v, lat);
        chk("R8 first stage spurious vector", 16'(v), 16'd7);
        chk("R8 spurious latency", 16'(lat), 16'd1);
        req_i = 16'h0080;
        settle();
        chk("R8 no level marked in service", 16'(irq_o), 16'd1);
        req_i = '0;
        bus_write(1'b1, 1'b1, 8'h00);
        req_i = 16'h0200;
        settle();
        do_ack(1'b1, v, lat);
        chk("R8 second stage spurious vector", 16'(v), 16'd15);
        chk("R8 second stage spurious latency", 16'(lat), 16'd2);
    endtask

    initial begin
        t_reset();
        t_mask();
        t_priority();
        t_cascade();
        t_spurious();
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule